// File: doc/BRIEF.md
# Two-Wire Command Slave with Busy Handshake

This block is the target side of a synchronous serial link that uses two wires: a clock that the master always generates, and one data line that both sides drive in turn. The master shifts a 16-bit command into the block, most significant bit first. The master moves data on the falling clock edge and the block samples it on the rising edge. When the sixteenth bit has arrived, the master lets go of the data line. The block then drives the line high for as long as it is busy.

On the system side, the block hands over the received word on a valid/ready stream. It then waits for a response word on a second valid/ready stream. Command stream: `cmd_valid_o` rises with the word and stays high, with `cmd_data_o` frozen, until `cmd_ready_i` is sampled high; the consumer may hold it back for any number of cycles. Response stream: `rsp_ready_o` is high only after the command has been taken and while no response is held; a response is captured on the first clock edge where `rsp_valid_i` and `rsp_ready_o` are both high.

After capture, the block pulls the data line low for a fixed interval (15 µs at the default clock) to announce the response. It then shifts the response out on the master's clock and releases the line. Only one command is in flight at a time. Both serial inputs pass through two-flop synchronisers, so the block reacts to a serial edge on the third system clock edge after the input changes.

Top module: `twcs_link_slave`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the block returns to command receive; after that edge `ser_dat_oe`, `cmd_valid_o` and `rsp_ready_o` are low.
- R2: In command receive, each rising `ser_clk_i` edge takes one bit from `ser_dat_i`, and the first bit is bit 15. After the sixteenth rise, `cmd_valid_o` goes high with the word on `cmd_data_o`, and both hold until `cmd_ready_i` is high at a `clk` edge. Outputs react on the third `clk` edge after a serial input change.
- R3: From the sixteenth command bit until a response is captured, `ser_dat_oe` is 1 and `ser_dat_o` is 1.
- R4: `rsp_ready_o` is high only while the block is busy and its command has already been accepted. `rsp_valid_i` has no effect at any other time.
- R5: Starting at the capture edge, the block drives the line low for exactly PULSE_CYCLES = CLK_HZ·PULSE_NS/10^9 system cycles (750 at the defaults).
- R6: After the low interval the line carries response bit 15. Each falling `ser_clk_i` edge that follows at least one rising edge moves the line to the next lower bit, so a master sampling on sixteen rising edges reads the whole word.
- R7: The first falling `ser_clk_i` edge after the sixteenth response rise sets `ser_dat_oe` low and returns the block to command receive, ready for the next command.
- R8: `ser_clk_i` edges have no effect while the block is busy or timing the low interval: no bit is taken, `cmd_data_o` is unchanged, and the line level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock from the master |
| ser_dat_i | input | 1 | Level seen on the shared data line |
| ser_dat_o | output | 1 | Level the block drives onto the data line |
| ser_dat_oe | output | 1 | High while the block drives the data line |
| cmd_data_o | output | 16 | Received command word |
| cmd_valid_o | output | 1 | Command word available |
| cmd_ready_i | input | 1 | Consumer accepts the command word |
| rsp_data_i | input | 16 | Response word to send |
| rsp_valid_i | input | 1 | Response word offered |
| rsp_ready_o | output | 1 | Block can capture a response |

## Verification
Commands and responses are run with all-zero, all-one, alternating and mixed words. This shows bit order and shows that a line held low for a response whose top bit is 0 runs straight on from the low interval. The consumer is made to hold back the command for several cycles while the bench offers a response too early, which separates the command hold (R2) from response gating (R4). One transaction toggles the serial clock while the block is busy (R8). Several transactions run back to back, which shows that the line is released and the block re-arms after each response (R7).

// File: rtl/twcs_pkg.sv
package twcs_pkg;
  typedef enum logic [1:0] {
    LINK_IDLE  = 2'd0,
    LINK_BUSY  = 2'd1,
    LINK_PULSE = 2'd2,
    LINK_SEND  = 2'd3
  } link_state_e;
endpackage

// File: rtl/twcs_sync.sv
module twcs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/twcs_edge.sv
module twcs_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level_i;
  end

  assign rise_o = level_i & ~prev;
  assign fall_o = ~level_i & prev;
endmodule

// File: rtl/twcs_shift.sv
module twcs_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] word_o,
  output logic         msb_o
);
  logic [W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst)          word <= '0;
    else if (load_i)  word <= load_val_i;
    else if (shift_i) word <= {word[W-2:0], ser_i};
  end

  assign word_o = word;
  assign msb_o  = word[W-1];
endmodule

// File: rtl/twcs_pulse_timer.sv
module twcs_pulse_timer #(
  parameter int CYCLES = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  output logic done_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active_i) cnt <= '0;
    else if (!done_o)     cnt <= cnt + CNT_W'(1);
  end

  assign done_o = active_i && (cnt == LAST);
endmodule

// File: rtl/twcs_link_slave.sv
module twcs_link_slave
  import twcs_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CLK_HZ      = 50_000_000,
  parameter int PULSE_NS    = 15_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              ser_dat_o,
  output logic              ser_dat_oe,
  output logic [WORD_W-1:0] cmd_data_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  input  logic [WORD_W-1:0] rsp_data_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o
);
  localparam int PULSE_CYCLES = ((CLK_HZ / 1000) * (PULSE_NS / 1000)) / 1000;
  localparam int BIT_W        = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] ALL_BITS = BIT_W'(WORD_W);

  link_state_e      state;
  logic [BIT_W-1:0] bit_cnt;
  logic             cmd_pend;
  logic             sclk_s, sdat_s;
  logic             sclk_rise, sclk_fall;
  logic             pulse_done;
  logic             rsp_take;
  logic             tx_msb;
  logic             rx_shift, tx_shift;
  logic [WORD_W-1:0] tx_word;

  twcs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_clk_i, ser_dat_i}),
    .sync_o  ({sclk_s, sdat_s})
  );

  twcs_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (sclk_s),
    .rise_o  (sclk_rise),
    .fall_o  (sclk_fall)
  );

  assign rx_shift = (state == LINK_IDLE) && sclk_rise;

  twcs_shift #(.W(WORD_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .load_i     (1'b0),
    .load_val_i ('0),
    .shift_i    (rx_shift),
    .ser_i      (sdat_s),
    .word_o     (cmd_data_o),
    .msb_o      ()
  );

  assign rsp_take = rsp_valid_i && rsp_ready_o;
  assign tx_shift = (state == LINK_SEND) && sclk_fall &&
                    (bit_cnt != '0) && (bit_cnt != ALL_BITS);

  twcs_shift #(.W(WORD_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .load_i     (rsp_take),
    .load_val_i (rsp_data_i),
    .shift_i    (tx_shift),
    .ser_i      (1'b0),
    .word_o     (tx_word),
    .msb_o      (tx_msb)
  );

  twcs_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .active_i (state == LINK_PULSE),
    .done_o   (pulse_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LINK_IDLE;
      bit_cnt  <= '0;
      cmd_pend <= 1'b0;
    end else begin
      unique case (state)
        LINK_IDLE: begin
          if (sclk_rise) begin
            if (bit_cnt == LAST_BIT) begin
              state    <= LINK_BUSY;
              bit_cnt  <= '0;
              cmd_pend <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + BIT_W'(1);
            end
          end
        end
        LINK_BUSY: begin
          if (cmd_pend) begin
            if (cmd_ready_i) cmd_pend <= 1'b0;
          end else if (rsp_valid_i) begin
            state <= LINK_PULSE;
          end
        end
        LINK_PULSE: begin
          if (pulse_done) begin
            state   <= LINK_SEND;
            bit_cnt <= '0;
          end
        end
        LINK_SEND: begin
          if (sclk_rise) begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end else if (sclk_fall && bit_cnt == ALL_BITS) begin
            state   <= LINK_IDLE;
            bit_cnt <= '0;
          end
        end
        default: state <= LINK_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      LINK_BUSY:  ser_dat_o = 1'b1;
      LINK_SEND:  ser_dat_o = tx_msb;
      default:    ser_dat_o = 1'b0;
    endcase
  end

  assign ser_dat_oe  = (state != LINK_IDLE);
  assign cmd_valid_o = cmd_pend;
  assign rsp_ready_o = (state == LINK_BUSY) && !cmd_pend;

  logic unused_tx;
  assign unused_tx = ^tx_word;
endmodule

// File: rtl/twcs_link_checker.sv
module twcs_link_checker #(
  parameter int WORD_W       = 16,
  parameter int PULSE_CYCLES = 750
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_dat_o,
  input logic              ser_dat_oe,
  input logic [WORD_W-1:0] cmd_data_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic              rsp_valid_i,
  input logic              rsp_ready_o
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)                                         low_run <= 0;
    else if (rsp_valid_i && rsp_ready_o)             low_run <= 1;
    else if (low_run != 0 && low_run < PULSE_CYCLES) low_run <= low_run + 1;
    else                                             low_run <= 0;
  end

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o)); // R2
  AST_BUSY_HIGH: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> ser_dat_oe && ser_dat_o); // R3
  AST_RSP_GATED: assert property (@(posedge clk) disable iff (rst)
    rsp_ready_o |-> !cmd_valid_o && ser_dat_oe && ser_dat_o); // R4
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (rst)
    (low_run != 0) |-> ser_dat_oe && !ser_dat_o); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid_o) |-> $past(!ser_dat_oe)); // R8
endmodule

bind twcs_link_slave twcs_link_checker #(
  .WORD_W(WORD_W), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ser_dat_o   (ser_dat_o),
  .ser_dat_oe  (ser_dat_oe),
  .cmd_data_o  (cmd_data_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ready_o (rsp_ready_o)
);

// File: tb/twcs_link_slave_test.sv
module twcs_link_slave_test;
  localparam int PULSE = 750;
  localparam int H     = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, sclk, m_en, m_dat, line;
  logic        dat_o, dat_oe, cmd_valid, cmd_ready, rsp_valid, rsp_ready;
  logic [15:0] cmd_data, rsp_data;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always_comb line = dat_oe ? dat_o : (m_en ? m_dat : 1'b1);

  twcs_link_slave uut (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(line),
    .ser_dat_o(dat_o), .ser_dat_oe(dat_oe),
    .cmd_data_o(cmd_data), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .rsp_data_i(rsp_data), .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: history of sampled inputs, phase number, counters
  bit hk[4];
  bit hd[3];
  int ms, mbits, mcnt, mrise;
  bit mpend;
  logic [15:0] mcmd, mrsp;

  always @(posedge clk) begin
    bit rise, fall;
    if (rst) begin
      for (int i = 0; i < 4; i++) hk[i] = 0;
      for (int i = 0; i < 3; i++) hd[i] = 0;
      ms = 0; mbits = 0; mcnt = 0; mrise = 0; mpend = 0; mcmd = '0;
    end else begin
      hk[3] = hk[2]; hk[2] = hk[1]; hk[1] = hk[0]; hk[0] = sclk;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = line;
      rise = hk[2] && !hk[3];
      fall = !hk[2] && hk[3];
      case (ms)
        0: if (rise) begin
             mcmd = {mcmd[14:0], hd[2]};
             mbits++;
             if (mbits == 16) begin ms = 1; mbits = 0; mpend = 1; end
           end
        1: if (mpend) begin
             if (cmd_ready) mpend = 0;
           end else if (rsp_valid) begin
             mrsp = rsp_data; ms = 2; mcnt = 0;
           end
        2: begin
             mcnt++;
             if (mcnt == PULSE) begin ms = 3; mrise = 0; end
           end
        default: if (rise) mrise++;
                 else if (fall && mrise > 0) begin
                   if (mrise == 16) ms = 0;
                   else mrsp = {mrsp[14:0], 1'b0};
                 end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(dat_oe == (ms != 0), "R7", "line enable vs model", dat_oe, ms != 0);
      if (ms != 0) begin
        logic e;
        e = (ms == 1) ? 1'b1 : (ms == 2) ? 1'b0 : mrsp[15];
        chk(dat_o == e, "R6", "driven level vs model", dat_o, e);
      end
      chk(cmd_valid == mpend, "R2", "cmd_valid vs model", cmd_valid, mpend);
      if (mpend) chk(cmd_data == mcmd, "R2", "cmd_data vs model", cmd_data, mcmd);
      chk(rsp_ready == (ms == 1 && !mpend), "R4", "rsp_ready vs model",
          rsp_ready, ms == 1 && !mpend);
    end
  end

  task automatic send_cmd(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      m_en = 1; m_dat = w[i];
      repeat (H) @(negedge clk);
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    m_en = 0;
  endtask

  task automatic run_txn(input logic [15:0] c, input logic [15:0] r,
                         input int dly, input bit early, input bit poke);
    logic [15:0] got;
    int lowcnt, w;
    send_cmd(c);
    w = 0;
    while (!cmd_valid && w < 50) begin @(negedge clk); w++; end
    chk(cmd_valid == 1, "R2", "command strobe", cmd_valid, 1);
    chk(cmd_data == c, "R2", "command word", cmd_data, c);
    chk(dat_oe && dat_o, "R3", "busy level", {dat_oe, dat_o}, 3);
    if (early) begin
      rsp_valid = 1; rsp_data = r;
      for (int i = 0; i < dly + 2; i++) begin
        @(negedge clk);
        chk(rsp_ready == 0, "R4", "ready while command pending", rsp_ready, 0);
      end
      rsp_valid = 0;
    end
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        sclk = 1; repeat (H) @(negedge clk);
        sclk = 0; repeat (H) @(negedge clk);
      end
      chk(cmd_data == c, "R8", "word after busy clocks", cmd_data, c);
      chk(dat_oe && dat_o, "R8", "line after busy clocks", {dat_oe, dat_o}, 3);
    end
    repeat (dly) @(negedge clk);
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
    forever begin
      if (rsp_ready) break;
      @(negedge clk);
    end
    rsp_valid = 1; rsp_data = r;
    @(negedge clk);
    rsp_valid = 0;
    chk(dat_oe && !dat_o, "R5", "pulse start", {dat_oe, dat_o}, 2);
    lowcnt = 0;
    while (dat_oe && !dat_o && lowcnt < PULSE + 10) begin
      lowcnt++; @(negedge clk);
    end
    if (r[15]) chk(lowcnt == PULSE, "R5", "pulse length", lowcnt, PULSE);
    got = '0;
    for (int i = 0; i < 16; i++) begin
      repeat (H) @(negedge clk);
      got = {got[14:0], line};
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    chk(got == r, "R6", "response word", got, r);
    repeat (6) @(negedge clk);
    chk(dat_oe == 0, "R7", "line released", dat_oe, 0);
  endtask

  initial begin
    rst = 1; sclk = 0; m_en = 0; m_dat = 0;
    cmd_ready = 0; rsp_valid = 0; rsp_data = '0;
    repeat (5) @(negedge clk);
    chk(dat_oe == 0 && cmd_valid == 0 && rsp_ready == 0, "R1", "reset state",
        {dat_oe, cmd_valid, rsp_ready}, 0);
    rst = 0;
    repeat (4) @(negedge clk);
    run_txn(16'hA5C3, 16'h8001, 0, 0, 0);
    run_txn(16'h0000, 16'hFFFF, 3, 1, 0);
    run_txn(16'hFFFF, 16'h0000, 1, 0, 1);
    run_txn(16'h1234, 16'hC0DE, 7, 1, 1);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] c;
      c = 16'h3C5A ^ (16'h1111 * 16'(k));
      run_txn(c, ~c, k, k[0], 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule